// File: doc/BRIEF.md
# Pad Attribute Register Bank

This block holds the electrical attribute word for every pad of a chip. Pads come in two groups, multiplexed pads and dedicated pads, and each pad owns one 13-bit attribute register. It covers inversion, open-drain modes, pull and keeper control, input hysteresis, slew rate and drive strength. The registers drive the pad cells directly through the block's attribute outputs.

Each register follows write-any-read-legal rules. A design-time support mask for each pad lists the attribute bits that pad really has. Write data is ANDed with that mask before it is stored. Unsupported bits therefore read as zero forever, and software finds out what a pad offers by writing ones and reading the result back.

Each pad also has a write-enable bit that software can clear but never set. A pad whose bit is cleared keeps its attribute word until the next reset. Access goes through a plain single-cycle register port with an address, write data, a write strobe and a combinational read path.

Top module: `padattr_bank`

## Requirements
- R1: After reset every attribute output is zero and every pad's write-enable bit reads as 1.
- R2: The attribute word has these bit positions: bit 0 inverts input and output, bit 1 enables virtual open drain, bit 2 enables the pull, bit 3 picks the pull direction (1 up, 0 down), bit 4 enables the keeper, bit 5 enables the Schmitt trigger, bit 6 enables real open drain, bits 8:7 set the slew rate (0 slowest, 3 fastest) and bits 12:9 set the drive strength (0 weakest, 15 strongest).
- R3: A write to an attribute address of an unlocked pad stores `wdata_i[12:0]` ANDed with that pad's support mask. The stored value appears on the pad's output after the clock edge that samples the write.
- R4: A bit that a pad's mask does not support always reads and drives as zero, even right after a write of one to it. With the default masks, multiplexed pad 2 has only two drive-strength bits (it keeps `0x07FF` of `0x1FFF`), and dedicated pad 1 lacks bits 1 and 4 (it keeps `0x1FED` of `0x1FFF`).
- R5: A write to a pad's lock address with `wdata_i[0]` = 0 clears that pad's write-enable bit. A write with `wdata_i[0]` = 1 leaves the bit unchanged, and a cleared bit stays cleared until reset.
- R6: While a pad's write-enable bit is 0, writes to its attribute address leave its attribute word unchanged.
- R7: The address map uses word addresses. Addresses 0 to NUM_MUX-1 are the multiplexed pads' attributes. The next NUM_DED addresses are the dedicated pads' attributes. The following NUM_MUX+NUM_DED addresses are the write-enable bits in the same pad order. A read returns the attribute word zero-extended, or the write-enable bit in bit 0 with the other bits zero, in the same cycle as the address.
- R8: A read of an address at or above 2*(NUM_MUX+NUM_DED) returns zero, and a write to such an address changes no attribute word and no write-enable bit.
- R9: A write to one pad, or a cycle with no write, leaves every other pad's attribute word and write-enable bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address for reads and writes |
| wdata_i | input | DATA_W | Write data |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| rdata_o | output | DATA_W | Combinational read data for `addr_i` |
| mux_attr_o | output | NUM_MUX x 13 | Attribute words of the multiplexed pads |
| ded_attr_o | output | NUM_DED x 13 | Attribute words of the dedicated pads |

## Verification
A write becomes visible one clock edge after the strobe is sampled. The bench raises the strobe on a falling edge and drops it on the next falling edge, and it compares both attribute output buses against its model at that falling edge. Reads have no register in their path. The bench sets the address with the strobe low, waits one time unit and then compares `rdata_o`. Lock clears follow the same one-edge rule, so the first write after a clear is already expected to be dropped.

// File: rtl/padattr_pkg.sv
package padattr_pkg;

   localparam int unsigned ATTR_W = 13;

   // Attribute word, MSB first; bit positions are fixed by the pad cells.
   typedef struct packed {
      logic [3:0] drive;      // 12:9
      logic [1:0] slew;       // 8:7
      logic       open_drain; // 6
      logic       schmitt;    // 5
      logic       keeper;     // 4
      logic       pull_up;    // 3
      logic       pull_en;    // 2
      logic       virt_od;    // 1
      logic       invert;     // 0
   } pad_attr_t;

   localparam logic [ATTR_W-1:0] FULL_MASK = '1;

endpackage

// File: rtl/padattr_dec.sv
module padattr_dec #(
   parameter int unsigned NP     = 6,
   parameter int unsigned ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [NP-1:0]     attr_sel_o,
   output logic [NP-1:0]     lock_sel_o
);

   always_comb begin
      for (int i = 0; i < NP; i++) begin
         attr_sel_o[i] = (addr_i == ADDR_W'(i));
         lock_sel_o[i] = (addr_i == ADDR_W'(NP + i));
      end
   end

endmodule

// File: rtl/padattr_slot.sv
module padattr_slot #(
   parameter int unsigned       ATTR_W    = 13,
   parameter logic [ATTR_W-1:0] MASK      = '1,
   parameter bit                LOCK_IMPL = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              attr_we_i,
   input  logic              lock_we_i,
   input  logic [ATTR_W-1:0] wdata_i,
   output logic [ATTR_W-1:0] attr_o,
   output logic              wen_o
);

   logic store;
   assign store = attr_we_i & wen_o;

   // Flops only for implemented bits; the rest are tied low.
   for (genvar b = 0; b < ATTR_W; b++) begin : g_bit
      if (MASK[b]) begin : g_ff
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)    attr_o[b] <= 1'b0;
            else if (store) attr_o[b] <= wdata_i[b];
         end
      end else begin : g_tie
         assign attr_o[b] = 1'b0;
      end
   end

   if (LOCK_IMPL) begin : g_lock
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                      wen_o <= 1'b1;
         else if (lock_we_i && !wdata_i[0]) wen_o <= 1'b0;
      end
   end else begin : g_nolock
      assign wen_o = 1'b1;
      logic unused_lock;
      assign unused_lock = lock_we_i;
   end

   logic unused_wdata;
   assign unused_wdata = ^(wdata_i & ~MASK);

endmodule

// File: rtl/padattr_rdmux.sv
module padattr_rdmux #(
   parameter int unsigned NP     = 6,
   parameter int unsigned ATTR_W = 13,
   parameter int unsigned DATA_W = 32
) (
   input  logic [NP-1:0][ATTR_W-1:0] attr_i,
   input  logic [NP-1:0]             wen_i,
   input  logic [NP-1:0]             attr_sel_i,
   input  logic [NP-1:0]             lock_sel_i,
   output logic [DATA_W-1:0]         rdata_o
);

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NP; i++) begin
         if (attr_sel_i[i]) rdata_o = rdata_o | DATA_W'(attr_i[i]);
         if (lock_sel_i[i]) rdata_o = rdata_o | DATA_W'(wen_i[i]);
      end
   end

endmodule

// File: rtl/padattr_bank.sv
module padattr_bank
   import padattr_pkg::*;
#(
   parameter int unsigned NUM_MUX   = 4,
   parameter int unsigned NUM_DED   = 2,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 32,
   parameter bit          LOCK_IMPL = 1'b1,
   parameter logic [NUM_MUX-1:0][ATTR_W-1:0] MUX_MASK =
      {13'h1FFF, 13'h07FF, 13'h1FFF, 13'h1FFF},
   parameter logic [NUM_DED-1:0][ATTR_W-1:0] DED_MASK =
      {13'h1FED, 13'h1FFF}
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic [ADDR_W-1:0]                addr_i,
   input  logic [DATA_W-1:0]                wdata_i,
   input  logic                             wr_en_i,
   output logic [DATA_W-1:0]                rdata_o,
   output logic [NUM_MUX-1:0][ATTR_W-1:0]   mux_attr_o,
   output logic [NUM_DED-1:0][ATTR_W-1:0]   ded_attr_o
);

   localparam int unsigned NP = NUM_MUX + NUM_DED;
   localparam logic [NP-1:0][ATTR_W-1:0] ALL_MASK = {DED_MASK, MUX_MASK};

   if (NUM_MUX < 1 || NUM_DED < 1) begin : g_bad_count
      $error("padattr_bank: each pad group needs at least one pad");
   end
   if (DATA_W < ATTR_W) begin : g_bad_width
      $error("padattr_bank: DATA_W narrower than the attribute word");
   end
   if (2 * NP > (1 << ADDR_W)) begin : g_bad_addr
      $error("padattr_bank: ADDR_W too small for the register map");
   end

   logic [NP-1:0][ATTR_W-1:0] attr_all;
   logic [NP-1:0]             wen_all;
   logic [NP-1:0]             attr_sel;
   logic [NP-1:0]             lock_sel;

   padattr_dec #(.NP(NP), .ADDR_W(ADDR_W)) u_dec (
      .addr_i     (addr_i),
      .attr_sel_o (attr_sel),
      .lock_sel_o (lock_sel)
   );

   for (genvar i = 0; i < NP; i++) begin : g_pad
      padattr_slot #(
         .ATTR_W    (ATTR_W),
         .MASK      (ALL_MASK[i]),
         .LOCK_IMPL (LOCK_IMPL)
      ) u_slot (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .attr_we_i (attr_sel[i] & wr_en_i),
         .lock_we_i (lock_sel[i] & wr_en_i),
         .wdata_i   (wdata_i[ATTR_W-1:0]),
         .attr_o    (attr_all[i]),
         .wen_o     (wen_all[i])
      );
   end

   padattr_rdmux #(.NP(NP), .ATTR_W(ATTR_W), .DATA_W(DATA_W)) u_rd (
      .attr_i     (attr_all),
      .wen_i      (wen_all),
      .attr_sel_i (attr_sel),
      .lock_sel_i (lock_sel),
      .rdata_o    (rdata_o)
   );

   assign mux_attr_o = attr_all[NUM_MUX-1:0];
   assign ded_attr_o = attr_all[NP-1:NUM_MUX];

   if (DATA_W > ATTR_W) begin : g_wide
      logic unused_upper;
      assign unused_upper = ^wdata_i[DATA_W-1:ATTR_W];
   end

endmodule

// File: rtl/padattr_bank_chk.sv
module padattr_bank_chk #(
   parameter int unsigned NP     = 6,
   parameter int unsigned ATTR_W = 13,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter logic [NP-1:0][ATTR_W-1:0] MASK = '1
) (
   input logic                      clk_i,
   input logic                      rst_ni,
   input logic [ADDR_W-1:0]         addr_i,
   input logic [DATA_W-1:0]         wdata_i,
   input logic                      wr_en_i,
   input logic [DATA_W-1:0]         rdata_o,
   input logic [NP-1:0][ATTR_W-1:0] attr_all,
   input logic [NP-1:0]             wen_all
);

   localparam int unsigned MAP_END = 2 * NP;

   logic unmapped;
   assign unmapped = (32'(addr_i) >= MAP_END);

   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(attr_all) && $stable(wen_all)); // R9

   AST_UNMAPPED_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && unmapped |=> $stable(attr_all) && $stable(wen_all)); // R8

   AST_UNMAPPED_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unmapped |-> rdata_o == '0); // R8

   for (genvar i = 0; i < NP; i++) begin : g_pad
      AST_ONLY_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (attr_all[i] & ~MASK[i]) == '0); // R4

      AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !wen_all[i] |=> $stable(attr_all[i])); // R6

      AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !wen_all[i] |=> !wen_all[i]); // R5

      AST_LOCK_ONE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
         wr_en_i && addr_i == ADDR_W'(NP + i) && wdata_i[0]
         |=> $stable(wen_all[i])); // R5

      AST_WRITE_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
         wr_en_i && addr_i == ADDR_W'(i) && wen_all[i]
         |=> attr_all[i] == ($past(wdata_i[ATTR_W-1:0]) & MASK[i])); // R3
   end

endmodule

bind padattr_bank padattr_bank_chk #(
   .NP     (NP),
   .ATTR_W (ATTR_W),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .MASK   (ALL_MASK)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .addr_i   (addr_i),
   .wdata_i  (wdata_i),
   .wr_en_i  (wr_en_i),
   .rdata_o  (rdata_o),
   .attr_all (attr_all),
   .wen_all  (wen_all)
);

// File: tb/tb_padattr_bank.sv
module tb_padattr_bank;
   import padattr_pkg::*;

   localparam int CLK_P = 10;
   localparam int NM = 4;
   localparam int ND = 2;
   localparam int NP = NM + ND;
   localparam int AW = 4;
   localparam int DW = 32;
   localparam logic [NM-1:0][12:0] M_MASK = {13'h1FFF, 13'h07FF, 13'h1FFF, 13'h1FFF};
   localparam logic [ND-1:0][12:0] D_MASK = {13'h1FED, 13'h1FFF};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic wr_en = 1'b0;
   logic [DW-1:0] rdata;
   logic [NM-1:0][12:0] mux_attr;
   logic [ND-1:0][12:0] ded_attr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [12:0] exp_attr [NP];
   logic        exp_wen  [NP];

   always #(CLK_P/2) clk = ~clk;

   padattr_bank #(.NUM_MUX(NM), .NUM_DED(ND), .ADDR_W(AW), .DATA_W(DW),
                  .MUX_MASK(M_MASK), .DED_MASK(D_MASK)) dut (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
      .wr_en_i(wr_en), .rdata_o(rdata), .mux_attr_o(mux_attr), .ded_attr_o(ded_attr)
   );

   function automatic logic [12:0] pad_mask(int i);
      if (i < NM) return M_MASK[i];
      return D_MASK[i-NM];
   endfunction

   function automatic logic [12:0] pad_out(int i);
      if (i < NM) return mux_attr[i];
      return ded_attr[i-NM];
   endfunction

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(int a, logic [DW-1:0] d);
      @(negedge clk);
      addr = AW'(a); wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      if (a < NP) begin
         if (exp_wen[a]) exp_attr[a] = d[12:0] & pad_mask(a);
      end else if (a < 2*NP) begin
         if (!d[0]) exp_wen[a-NP] = 1'b0;
      end
   endtask

   task automatic do_read(string req, int a);
      logic [DW-1:0] e;
      addr = AW'(a);
      #1;
      if (a < NP)          e = DW'(exp_attr[a]);
      else if (a < 2*NP)   e = DW'(exp_wen[a-NP]);
      else                 e = '0;
      chk(req, rdata, e);
   endtask

   task automatic check_pads(string req);
      for (int i = 0; i < NP; i++) chk(req, DW'(pad_out(i)), DW'(exp_attr[i]));
   endtask

   initial begin
      pad_attr_t pa;
      void'($urandom(32'h5A17));
      for (int i = 0; i < NP; i++) begin exp_attr[i] = '0; exp_wen[i] = 1'b1; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check_pads("R1");
      for (int i = 0; i < NP; i++) do_read("R1", NP + i);

      // R2: field positions, pull up and drive 9 -> 0x1208
      pa = '0; pa.pull_up = 1'b1; pa.drive = 4'h9;
      do_write(0, DW'(pa));
      chk("R2", DW'(mux_attr[0]), 32'h1208);
      pa = '0; pa.slew = 2'b10; pa.invert = 1'b1;
      do_write(1, DW'(pa));
      chk("R2", DW'(mux_attr[1]), 32'h0101);

      // R4: unsupported bits read zero
      do_write(2, 32'hFFFF_FFFF);
      chk("R4", DW'(mux_attr[2]), 32'h07FF);
      do_read("R4", 2);
      do_write(5, 32'h0000_1FFF);
      chk("R4", DW'(ded_attr[1]), 32'h1FED);

      // R7: read is zero-extended
      do_write(1, 32'hFFFF_FFFF);
      addr = AW'(1); #1; chk("R7", rdata, 32'h0000_1FFF);
      do_read("R7", NP + 3);

      // R5: writing 1 to a lock has no effect, writing 0 clears it
      do_write(NP + 3, 32'h1);
      addr = AW'(NP + 3); #1; chk("R5", rdata, 32'h1);
      do_write(3, 32'h0000_0AAA);
      do_write(NP + 3, 32'hFFFF_FFFE);
      addr = AW'(NP + 3); #1; chk("R5", rdata, 32'h0);
      do_write(NP + 3, 32'h1);
      addr = AW'(NP + 3); #1; chk("R5", rdata, 32'h0);

      // R6: locked pad keeps its word
      do_write(3, 32'h0000_1555);
      chk("R6", DW'(mux_attr[3]), 32'h0AAA);
      // R9: other pads still writable
      do_write(0, 32'h0000_0033);
      chk("R9", DW'(mux_attr[0]), 32'h0033);
      check_pads("R9");

      // R8: unmapped addresses
      for (int a = 2*NP; a < (1 << AW); a++) begin
         do_write(a, 32'h0000_0000);
         check_pads("R8");
         do_read("R8", a);
      end

      // Random mix: R3, R7, R9
      for (int n = 0; n < 400; n++) begin
         int a;
         logic [DW-1:0] d;
         a = int'($urandom % (1 << AW));
         d = $urandom;
         if (a >= NP && a < 2*NP) d[0] = ($urandom % 24 == 0) ? 1'b0 : 1'b1;
         do_write(a, d);
         check_pads("R3");
         do_read("R7", int'($urandom % (1 << AW)));
      end

      // R6: lock every pad, then writes must not land
      for (int i = 0; i < NP; i++) do_write(NP + i, 32'h0);
      for (int i = 0; i < NP; i++) do_write(i, ~DW'(exp_attr[i]));
      check_pads("R6");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule